// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in in pure combinational logic and returns a 16-bit sum and a carry-out. The operands are split into four 4-bit groups. Inside each group, every carry is a flat sum-of-products of the bit-level generate and propagate terms and the group's carry-in, so no carry passes from bit to bit. A second lookahead stage takes the four group-level generate and propagate terms and the adder's carry-in, and forms the carry into each group in the same flat style. No carry passes from group to group either.

Bit-level generate is the AND of the two operand bits. Bit-level propagate is their XOR, and the same XOR term forms the sum bit once the carry into that bit is known. The adder also brings out its own block-level generate and propagate. These follow the same equations as the group terms, one level up. With them, four copies can feed a further lookahead stage to form a 64-bit adder whose carries into each 16-bit slice come from lookahead and not from a chain.

Top module: `claAdder16`

## Requirements
- R1: For every input, {cout, sum} equals the 17-bit value a + b + cin.
- R2: grpProp is 1 exactly when a and b differ in every one of the 16 bit positions.
- R3: grpGen is 1 exactly when a + b, with carry-in taken as 0, carries out of bit 15.
- R4: When grpProp is 1, cout equals cin, and sum is 16'hFFFF for cin = 0 and 16'h0000 for cin = 1.
- R5: When grpGen is 1, cout is 1 whatever the value of cin.
- R6: cout always equals grpGen OR (grpProp AND cin), so that cascaded adders can receive their carries from a lookahead stage.
- R7: A carry formed in a lower 4-bit group reaches every higher group. Examples: 16'h000F + 16'h0001 gives 16'h0010, and 16'h0FFF + 16'h0001 gives 16'h1000.
- R8: All-zero inputs give sum = 0, cout = 0, grpGen = 0 and grpProp = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 15 |
| grpGen | output | 1 | Block generate: the block carries out even with no carry-in |
| grpProp | output | 1 | Block propagate: the block passes its carry-in through to its carry-out |

## Verification
The block holds no state. A wrong product term in a group or in the second-level stage therefore shows on the same input vector that needs that term. The symptom is a wrong sum bit at or above the group that term serves, or a wrong cout. The faults that are hardest to reach lie on long propagate chains and on carries that cross group boundaries. For that reason the directed vectors cover all-propagate operands with both carry-in values, single carries entering each group, and mixes of generating and killing patterns. The random vectors cover the remaining terms. The block-level generate and propagate outputs are checked against their definitions on every vector, so a term that only matters in a cascade still fails a check here.

// File: rtl/claPkg.sv
package claPkg;
  parameter int GROUP_W    = 4;
  parameter int NUM_GROUPS = 4;
  parameter int ADD_W      = GROUP_W * NUM_GROUPS;

  typedef struct packed {
    logic blkGen;
    logic blkProp;
  } gpPair_t;
endpackage

// File: rtl/claLookahead.sv
// Flat lookahead over N generate/propagate pairs. carryVec[j] is the carry into
// position j. Each carry is a direct OR of AND terms with no ripple between
// positions. The block-level pair obeys the same equations with carry-in zero.
module claLookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0]    gen,
  input  logic [N-1:0]    prop,
  input  logic            c0,
  output logic [N-1:0]    carryVec,
  output claPkg::gpPair_t blkGp
);
  // AND of prop[lo..hi], inclusive. Returns 1 when the range is empty.
  function automatic logic propRange(input logic [N-1:0] p, input int lo, input int hi);
    logic acc;
    acc = 1'b1;
    for (int m = 0; m < N; m++)
      if (m >= lo && m <= hi) acc = acc & p[m];
    return acc;
  endfunction

  // Carry into position j: c0 passed through every propagate below j, or
  // a generate at k passed through the propagates above k.
  function automatic logic sopCarry(input logic [N-1:0] g, input logic [N-1:0] p,
                                    input logic cIn, input int j);
    logic acc;
    acc = propRange(p, 0, j - 1) & cIn;
    for (int k = 0; k < N; k++)
      if (k < j) acc = acc | (g[k] & propRange(p, k + 1, j - 1));
    return acc;
  endfunction

  assign carryVec[0] = c0;

  genvar j;
  generate
    for (j = 1; j < N; j++) begin : g_carry
      assign carryVec[j] = sopCarry(gen, prop, c0, j);
    end
  endgenerate

  assign blkGp.blkGen  = sopCarry(gen, prop, 1'b0, N);
  assign blkGp.blkProp = propRange(prop, 0, N - 1);
endmodule

// File: rtl/claGroup.sv
// One bit-level group: per-bit generate/propagate, flat internal carries, sums.
module claGroup #(
  parameter int W = claPkg::GROUP_W
) (
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic            grpCin,
  output logic [W-1:0]    grpSum,
  output claPkg::gpPair_t grpGp
);
  logic [W-1:0] bitGen;
  logic [W-1:0] bitProp;
  logic [W-1:0] bitCarry;

  assign bitGen  = opA & opB;
  assign bitProp = opA ^ opB;   // XOR form serves both carry and sum

  claLookahead #(.N(W)) u_bitLook (
    .gen     (bitGen),
    .prop    (bitProp),
    .c0      (grpCin),
    .carryVec(bitCarry),
    .blkGp   (grpGp)
  );

  assign grpSum = bitProp ^ bitCarry;
endmodule

// File: rtl/claAdder16.sv
module claAdder16 #(
  parameter int GROUP_W    = claPkg::GROUP_W,
  parameter int NUM_GROUPS = claPkg::NUM_GROUPS
) (
  input  logic [GROUP_W*NUM_GROUPS-1:0] a,
  input  logic [GROUP_W*NUM_GROUPS-1:0] b,
  input  logic                          cin,
  output logic [GROUP_W*NUM_GROUPS-1:0] sum,
  output logic                          cout,
  output logic                          grpGen,
  output logic                          grpProp
);
  localparam int ADD_W = GROUP_W * NUM_GROUPS;

  logic [NUM_GROUPS-1:0] groupGen;
  logic [NUM_GROUPS-1:0] groupProp;
  logic [NUM_GROUPS-1:0] groupCin;
  claPkg::gpPair_t       topGp;

  genvar k;
  generate
    for (k = 0; k < NUM_GROUPS; k++) begin : g_group
      claPkg::gpPair_t gp;
      claGroup #(.W(GROUP_W)) u_group (
        .opA   (a[k*GROUP_W +: GROUP_W]),
        .opB   (b[k*GROUP_W +: GROUP_W]),
        .grpCin(groupCin[k]),
        .grpSum(sum[k*GROUP_W +: GROUP_W]),
        .grpGp (gp)
      );
      assign groupGen[k]  = gp.blkGen;
      assign groupProp[k] = gp.blkProp;
    end
  endgenerate

  // Second level: the carry into each group comes from the group terms (R7).
  claLookahead #(.N(NUM_GROUPS)) u_groupLook (
    .gen     (groupGen),
    .prop    (groupProp),
    .c0      (cin),
    .carryVec(groupCin),
    .blkGp   (topGp)
  );

  assign grpGen  = topGp.blkGen;
  assign grpProp = topGp.blkProp;
  assign cout    = topGp.blkGen | (topGp.blkProp & cin);

  logic unusedWidth;
  assign unusedWidth = (ADD_W == 0);
endmodule

// File: rtl/claAdder16Checker.sv
module claAdder16Checker #(
  parameter int ADD_W = 16
) (
  input logic [ADD_W-1:0] a,
  input logic [ADD_W-1:0] b,
  input logic             cin,
  input logic [ADD_W-1:0] sum,
  input logic             cout,
  input logic             grpGen,
  input logic             grpProp
);
  logic [ADD_W:0] wideSum;
  logic [ADD_W:0] noCinSum;
  logic           known;

  assign wideSum  = {1'b0, a} + {1'b0, b} + {{ADD_W{1'b0}}, cin};
  assign noCinSum = {1'b0, a} + {1'b0, b};
  assign known    = !$isunknown({a, b, cin, sum, cout, grpGen, grpProp});

  always_comb begin
    if (known) begin
      a_r1_total_matches: assert ({cout, sum} == wideSum);
      a_r2_prop_all_differ: assert (grpProp == (&(a ^ b)));
      a_r3_gen_no_cin_carry: assert (grpGen == noCinSum[ADD_W]);
      if (grpProp) begin
        a_r4_prop_passes_cin: assert (cout == cin && sum == {ADD_W{~cin}});
      end
      if (grpGen) begin
        a_r5_gen_forces_cout: assert (cout);
      end
      a_r6_cout_from_gp: assert (cout == (grpGen | (grpProp & cin)));
    end
  end
endmodule

bind claAdder16 claAdder16Checker #(.ADD_W(GROUP_W*NUM_GROUPS)) u_checker (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .grpGen(grpGen), .grpProp(grpProp)
);

// File: tb/tb_claAdder16.sv
module tb_claAdder16;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  logic         grpGen;
  logic         grpProp;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  claAdder16 dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
    .grpGen(grpGen), .grpProp(grpProp)
  );

  function automatic logic [W:0] expTotal(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic expGen(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y};
    return t[W];
  endfunction

  function automatic logic expProp(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x ^ y) == {W{1'b1}};
  endfunction

  task automatic tally(input logic ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic applyVec(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
    logic [W:0] t;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    t = expTotal(x, y, c);
    tally({cout, sum} == t, {"R1 ", tag}, {cout, sum}, t);
    tally(grpProp == expProp(x, y), "R2", {{W{1'b0}}, grpProp}, {{W{1'b0}}, expProp(x, y)});
    tally(grpGen == expGen(x, y), "R3", {{W{1'b0}}, grpGen}, {{W{1'b0}}, expGen(x, y)});
    if (expProp(x, y))
      tally(cout == c && sum == {W{~c}}, "R4", {cout, sum}, {c, {W{~c}}});
    if (expGen(x, y))
      tally(cout == 1'b1, "R5", {{W{1'b0}}, cout}, {{W{1'b0}}, 1'b1});
    tally(cout == (grpGen | (grpProp & c)), "R6", {{W{1'b0}}, cout},
          {{W{1'b0}}, grpGen | (grpProp & c)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c1a0));
    // R8: zero inputs
    @(negedge clk);
    tally(sum == '0 && !cout && !grpGen && !grpProp, "R8",
          {cout, sum} | {{W{1'b0}}, grpGen | grpProp}, '0);
    applyVec(16'h0000, 16'h0000, 1'b0, "zero");
    // R4: all-propagate chains, both carry-in values
    applyVec(16'hFFFF, 16'h0000, 1'b1, "R4 allprop cin1");
    applyVec(16'hFFFF, 16'h0000, 1'b0, "R4 allprop cin0");
    applyVec(16'h5555, 16'hAAAA, 1'b1, "R4 alt");
    applyVec(16'h0F0F, 16'hF0F0, 1'b1, "R4 nibbles");
    // R5: generate at the top bit
    applyVec(16'h8000, 16'h8000, 1'b0, "R5 msb gen");
    applyVec(16'hFFFF, 16'hFFFF, 1'b1, "R5 all ones");
    applyVec(16'hFFFF, 16'h0001, 1'b0, "R5 long chain");
    // R7: carries crossing each group boundary
    applyVec(16'h000F, 16'h0001, 1'b0, "R7 g0->g1");
    applyVec(16'h00FF, 16'h0001, 1'b0, "R7 g1->g2");
    applyVec(16'h0FFF, 16'h0001, 1'b0, "R7 g2->g3");
    applyVec(16'h0FFF, 16'h0000, 1'b1, "R7 cin ripple");
    applyVec(16'h7FFF, 16'h0000, 1'b1, "R7 to msb");
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      if (i % 7 == 0) y = ~x;            // bias toward long propagate runs
      else if (i % 11 == 0) y = ~x ^ (16'h1 << (i % W));
      applyVec(x, y, 1'($urandom), "R1 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule